// File: doc/BRIEF.md
# Flash Status Polling Controller

This block sits on the host side of a parallel NOR flash and waits for a program or erase operation, already started by other logic, to finish. It does this by reading the device's status byte over and over through a simple read bus (address, read request, read data, ready). Each job names one address. For a program job this is the address being programmed. For an erase job it is any address inside a sector chosen for erase, because the device only reports valid status at such addresses.

Two polling methods can be picked per job. Data polling looks at bit 7, which the device holds inverted while it is busy and returns to its true value when it is done. Because bit 7 can settle before the low bits do, a match is followed by one more read, and that read supplies the final byte. Toggle polling reads the byte in pairs and compares bit 6 of the two reads, which keeps flipping while the device is busy. The first status read must only be issued after the last write of the command sequence. For that reason the controller only starts on an explicit start pulse and never reads while it is idle.

Failed polls are counted, and a job gives up with a timeout error once the count reaches a limit set for that job. The end of every job is marked by a one-cycle done pulse, which carries the final byte, or by a one-cycle error pulse.

Top module: `fpoll_ctrl`

## Requirements
- R1: `start` is taken only while `busy` is low. At that point the controller latches `mode`, `poll_addr`, `expect_b7` and `poll_limit`. A `start` pulse while busy has no effect on the running job: address, method, read count and result all stay the same.
- R2: Every read goes to the latched address. `bus_rd_req` stays high with `bus_addr` unchanged until `bus_rd_ready` is seen high at a rising clock edge, and that edge completes the read. No read is requested while the controller is idle.
- R3: When `mode` = 0 (data polling), a read whose bit 7 differs from `expect_b7` counts as one failed poll. A read whose bit 7 equals `expect_b7` is followed by exactly one confirm read. `expect_b7` = 1 for erase jobs.
- R4: In data polling, `done` presents on `final_data` all 8 bits of the confirm read, not the byte of the read that matched.
- R5: When `mode` = 1 (toggle polling), reads come in pairs. If bit 6 is equal in both reads of a pair, the job ends with `done` and `final_data` equal to the second read of the pair.
- R6: In toggle polling, a pair whose two bit 6 values differ counts as one failed poll, and the next pair is made of two new reads. The second read of the failed pair is not reused.
- R7: Each failed poll adds one to a 16-bit counter that is cleared when a job starts. When the count reaches `poll_limit`, `timeout_err` pulses, `busy` falls and no more reads are made. A limit of 0 behaves like a limit of 1. So a data job times out after `poll_limit` reads and a toggle job after 2×`poll_limit` reads.
- R8: `done` and `timeout_err` are single-cycle pulses and are never high together. Each is high in the cycle right after the rising edge that completes the last read of the job, and `busy` is low in that same cycle.
- R9: After synchronous reset the controller is idle: `busy`, `bus_rd_req`, `done` and `timeout_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start a polling job (taken only when idle) |
| mode | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| poll_addr | input | AW | Address to poll |
| expect_b7 | input | 1 | True value of bit 7 when the operation is done (1 for erase) |
| poll_limit | input | CW | Number of failed polls that causes a timeout |
| bus_addr | output | AW | Read address |
| bus_rd_req | output | 1 | Read request, held until ready |
| bus_rd_ready | input | 1 | Read completes at a rising edge where this and the request are high |
| bus_rd_data | input | 8 | Status byte returned by the flash |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse: the operation finished |
| timeout_err | output | 1 | One-cycle pulse: poll limit reached |
| final_data | output | 8 | Final byte, valid while `done` is high |

## Verification
Every result of this block shows up one cycle after the rising edge that completes the last read of a job. At that edge the controller registers `done` or `timeout_err`, sets `final_data` and drops `busy`. The bench's flash model hands out a scripted byte for each read, optionally after wait states, and counts each completed read at the next falling edge. The scoreboard monitor runs in the same falling-edge step and checks the pulse there, so the exact read count expected for each job (confirm read, pairs, failures up to the limit) also pins down the cycle of the pulse. In the following falling edge the monitor checks that the pulse is already gone.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    localparam int unsigned STATUS_W  = 8;
    localparam int unsigned DPOLL_BIT = 7;
    localparam int unsigned TOGG_BIT  = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } fp_state_e;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } fp_mode_e;

    typedef enum logic [1:0] {
        EV_NEXT   = 2'd0,
        EV_FINISH = 2'd1,
        EV_FAIL   = 2'd2
    } fp_event_e;

    typedef struct packed {
        fp_mode_e mode;
        logic     exp_b7;
    } fp_cfg_t;

    // bit 7 back at its true value
    function automatic logic dpoll_hit(input logic rd_b7, input logic exp_b7);
        return rd_b7 == exp_b7;
    endfunction

    // bit 6 held still across a read pair
    function automatic logic toggle_still(input logic first_b6, input logic second_b6);
        return first_b6 == second_b6;
    endfunction

endpackage

// File: rtl/fpoll_rd.sv
module fpoll_rd #(
    parameter int unsigned AW = 16
) (
    input  logic                           want,
    input  logic [AW-1:0]                  addr_in,
    input  logic                           bus_rd_ready,
    input  logic [fpoll_pkg::STATUS_W-1:0] bus_rd_data,
    output logic                           bus_rd_req,
    output logic [AW-1:0]                  bus_addr,
    output logic                           fire,
    output logic [fpoll_pkg::STATUS_W-1:0] rd_byte
);
    // request is a level held by the sequencer; the read ends on a ready edge
    assign bus_rd_req = want;
    assign bus_addr   = addr_in;
    assign fire       = want & bus_rd_ready;
    assign rd_byte    = bus_rd_data;
endmodule

// File: rtl/fpoll_cnt.sv
module fpoll_cnt #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          last
);
    localparam int unsigned XW = CW + 1;

    logic [CW-1:0] cnt_q;
    logic [XW-1:0] cnt_nxt;

    // the failure being counted now is the one that reaches the limit
    assign cnt_nxt = {1'b0, cnt_q} + XW'(1);
    assign last    = cnt_nxt >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_nxt[CW-1:0];
        end
    end
endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge
    import fpoll_pkg::*;
(
    input  fp_state_e state,
    input  fp_mode_e  mode,
    input  logic      exp_b7,
    input  logic      rd_b7,
    input  logic      rd_b6,
    input  logic      held_b6,
    output fp_event_e ev
);
    always_comb begin
        ev = EV_NEXT;
        unique case (state)
            ST_FIRST: begin
                if (mode == MODE_DATA) begin
                    ev = dpoll_hit(rd_b7, exp_b7) ? EV_NEXT : EV_FAIL;
                end else begin
                    ev = EV_NEXT;
                end
            end
            ST_SECOND: begin
                if (mode == MODE_DATA) begin
                    ev = EV_FINISH;
                end else begin
                    ev = toggle_still(held_b6, rd_b6) ? EV_FINISH : EV_FAIL;
                end
            end
            default: ev = EV_NEXT;
        endcase
    end
endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
    import fpoll_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                mode,
    input  logic [AW-1:0]       poll_addr,
    input  logic                expect_b7,
    input  logic [CW-1:0]       poll_limit,
    output logic [AW-1:0]       bus_addr,
    output logic                bus_rd_req,
    input  logic                bus_rd_ready,
    input  logic [STATUS_W-1:0] bus_rd_data,
    output logic                busy,
    output logic                done,
    output logic                timeout_err,
    output logic [STATUS_W-1:0] final_data
);
    fp_state_e           state_q;
    fp_cfg_t             cfg_q;
    logic [AW-1:0]       addr_q;
    logic [CW-1:0]       limit_q;
    logic                held_b6_q;

    logic                want;
    logic                fire;
    logic [STATUS_W-1:0] rd_byte;
    fp_event_e           ev;
    logic                cnt_last;
    logic                accept;

    assign want   = (state_q != ST_IDLE);
    assign busy   = want;
    assign accept = (state_q == ST_IDLE) && start;

    fpoll_rd #(.AW(AW)) u_rd (
        .want         (want),
        .addr_in      (addr_q),
        .bus_rd_ready (bus_rd_ready),
        .bus_rd_data  (bus_rd_data),
        .bus_rd_req   (bus_rd_req),
        .bus_addr     (bus_addr),
        .fire         (fire),
        .rd_byte      (rd_byte)
    );

    fpoll_judge u_judge (
        .state   (state_q),
        .mode    (cfg_q.mode),
        .exp_b7  (cfg_q.exp_b7),
        .rd_b7   (rd_byte[DPOLL_BIT]),
        .rd_b6   (rd_byte[TOGG_BIT]),
        .held_b6 (held_b6_q),
        .ev      (ev)
    );

    fpoll_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .inc   (fire && (ev == EV_FAIL)),
        .limit (limit_q),
        .last  (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '{mode: MODE_DATA, exp_b7: 1'b0};
            addr_q      <= '0;
            limit_q     <= '0;
            held_b6_q   <= 1'b0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            final_data  <= '0;
        end else begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q   <= '{mode: fp_mode_e'(mode), exp_b7: expect_b7};
                        addr_q  <= poll_addr;
                        limit_q <= poll_limit;
                        state_q <= ST_FIRST;
                    end
                end
                ST_FIRST, ST_SECOND: begin
                    if (fire) begin
                        unique case (ev)
                            EV_NEXT: begin
                                held_b6_q <= rd_byte[TOGG_BIT];
                                state_q   <= ST_SECOND;
                            end
                            EV_FINISH: begin
                                final_data <= rd_byte;
                                done       <= 1'b1;
                                state_q    <= ST_IDLE;
                            end
                            EV_FAIL: begin
                                if (cnt_last) begin
                                    timeout_err <= 1'b1;
                                    state_q     <= ST_IDLE;
                                end else begin
                                    state_q <= ST_FIRST;
                                end
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

module fpoll_ctrl_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          bus_rd_req,
    input logic          bus_rd_ready,
    input logic [AW-1:0] bus_addr,
    input logic          done,
    input logic          timeout_err
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_rd_req);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_req && !bus_rd_ready) |=> (bus_rd_req && $stable(bus_addr)));

    p_start_ignored_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(bus_rd_req && bus_rd_ready)) |=> (busy && $stable(bus_addr)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err);

    p_no_both_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout_err));

    p_end_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (done || timeout_err) |-> !busy);

    p_end_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        (done || timeout_err) |-> $past(bus_rd_req && bus_rd_ready));

    p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !timeout_err));
endmodule

bind fpoll_ctrl fpoll_ctrl_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .bus_rd_req   (bus_rd_req),
    .bus_rd_ready (bus_rd_ready),
    .bus_addr     (bus_addr),
    .done         (done),
    .timeout_err  (timeout_err)
);

// File: tb/sim_fpoll_ctrl.sv
module sim_fpoll_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic          expect_b7 = 1'b0;
    logic [CW-1:0] poll_limit = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_rd_req;
    logic          bus_rd_ready = 1'b0;
    logic [7:0]    bus_rd_data = 8'h00;
    logic          busy, done, timeout_err;
    logic [7:0]    final_data;

    fpoll_ctrl #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .poll_addr(poll_addr),
        .expect_b7(expect_b7), .poll_limit(poll_limit), .bus_addr(bus_addr),
        .bus_rd_req(bus_rd_req), .bus_rd_ready(bus_rd_ready), .bus_rd_data(bus_rd_data),
        .busy(busy), .done(done), .timeout_err(timeout_err), .final_data(final_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit         is_err;
        logic [7:0] data;
        int         reads;
        string      tag;
    } sb_item_t;

    sb_item_t      sb_q[$];
    logic [7:0]    resp_q[$];
    int            wait_n = 0;
    int            wcnt = 0;
    int            reads = 0;
    int            addr_bad = 0;
    bit            hs_pending = 0;
    bit            prev_pulse = 0;
    logic [AW-1:0] cur_addr = '0;
    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // flash model and scoreboard monitor, both at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (rst) begin
            bus_rd_ready = 1'b0;
            hs_pending   = 0;
            wcnt         = 0;
        end else begin
            if (hs_pending) begin
                if (resp_q.size() > 0) void'(resp_q.pop_front());
                reads++;
                wcnt = 0;
            end
            hs_pending = 0;
            if (bus_rd_req) begin
                if (wcnt >= wait_n) begin
                    bus_rd_ready = 1'b1;
                    bus_rd_data  = (resp_q.size() > 0) ? resp_q[0] : 8'h00;
                    hs_pending   = 1;
                    if (bus_addr !== cur_addr) addr_bad++;
                end else begin
                    bus_rd_ready = 1'b0;
                    wcnt++;
                end
            end else begin
                bus_rd_ready = 1'b0;
            end

            if (prev_pulse)
                check(!(done || timeout_err), "R8", "pulse longer than one cycle",
                      {done, timeout_err}, 0);
            prev_pulse = done || timeout_err;

            if (done || timeout_err) begin
                if (done && timeout_err) begin
                    check(0, "R8", "done and error together", 3, 1);
                end else if (sb_q.size() == 0) begin
                    check(0, "R8", "pulse with nothing expected", {done, timeout_err}, 0);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(timeout_err == it.is_err, it.tag, "outcome (1=timeout)",
                          timeout_err, it.is_err);
                    if (!it.is_err)
                        check(final_data == it.data, it.tag, "final data", final_data, it.data);
                    check(reads == it.reads, it.tag, "reads until pulse", reads, it.reads);
                    check(addr_bad == 0, "R2", "reads at a wrong address", addr_bad, 0);
                    check(!busy, "R8", "busy with end pulse", busy, 0);
                end
            end
        end
    end

    task automatic run_op(input bit m, input logic [AW-1:0] a, input bit e7,
                          input int lim, input int wn, input bit exp_err,
                          input logic [7:0] exp_data, input int exp_reads,
                          input string tag, input bit poke);
        sb_item_t it;
        int t;
        @(negedge clk);
        wait_n   = wn;
        reads    = 0;
        addr_bad = 0;
        cur_addr = a;
        it.is_err = exp_err;
        it.data   = exp_data;
        it.reads  = exp_reads;
        it.tag    = tag;
        sb_q.push_back(it);
        mode       = m;
        poll_addr  = a;
        expect_b7  = e7;
        poll_limit = CW'(lim);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        mode       = ~m;
        poll_addr  = ~a;
        expect_b7  = ~e7;
        poll_limit = '1;
        if (poke) begin
            repeat (3) @(negedge clk);
            start     = 1'b1;
            mode      = ~m;
            poll_addr = a ^ AW'(16'h00F0);
            @(negedge clk);
            start     = 1'b0;
        end
        t = 0;
        while (sb_q.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) begin
            check(0, tag, "watchdog, no end pulse", 0, 1);
            sb_q.delete();
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(!busy, "R9", "busy after reset", busy, 0);
        check(!done && !timeout_err, "R9", "pulses after reset", {done, timeout_err}, 0);
        check(!bus_rd_req, "R9", "request after reset", bus_rd_req, 0);
        repeat (4) @(negedge clk);
        check(!bus_rd_req, "R2", "request while idle", bus_rd_req, 0);

        // R3 R4: program job, bit 7 true value 0; match read 15, confirm 35
        resp_q = '{8'hCA, 8'hC0, 8'h15, 8'h35};
        run_op(1'b0, 16'h1234, 1'b0, 10, 0, 1'b0, 8'h35, 4, "R4", 1'b0);

        // R3 R4: erase job, match byte 8E, confirm FF, with a wait state
        resp_q = '{8'h00, 8'h40, 8'h8E, 8'hFF};
        run_op(1'b0, 16'h8001, 1'b1, 10, 1, 1'b0, 8'hFF, 4, "R3", 1'b0);

        // R7: data timeout after limit reads
        resp_q = {};
        for (int i = 0; i < 8; i++) resp_q.push_back(8'h00);
        run_op(1'b0, 16'h0040, 1'b1, 3, 0, 1'b1, 8'h00, 3, "R7", 1'b0);

        // R7: limit 0 acts as 1
        resp_q = {};
        for (int i = 0; i < 4; i++) resp_q.push_back(8'h11);
        run_op(1'b0, 16'h0041, 1'b1, 0, 0, 1'b1, 8'h00, 1, "R7", 1'b0);

        // R7 boundary: one failure below limit 2 still finishes
        resp_q = '{8'h00, 8'h80, 8'hFF};
        run_op(1'b0, 16'h0042, 1'b1, 2, 0, 1'b0, 8'hFF, 3, "R7", 1'b0);

        // R6: pairs never reuse a read (reads 2 and 3 agree but belong to different pairs)
        resp_q = '{8'h40, 8'h00, 8'h00, 8'h40, 8'h12, 8'h13};
        run_op(1'b1, 16'h2222, 1'b1, 5, 0, 1'b0, 8'h13, 6, "R6", 1'b0);

        // R7: toggle timeout after 2*limit reads
        resp_q = {};
        for (int i = 0; i < 10; i++) resp_q.push_back((i % 2 == 0) ? 8'h40 : 8'h00);
        run_op(1'b1, 16'h3333, 1'b1, 2, 0, 1'b1, 8'h00, 4, "R7", 1'b0);

        // R5: stable pair at once, with wait states
        resp_q = '{8'h5A, 8'h5B};
        run_op(1'b1, 16'h4444, 1'b0, 4, 3, 1'b0, 8'h5B, 2, "R5", 1'b0);

        // R1: start pulse while busy must not disturb the job
        resp_q = '{8'h00, 8'h00, 8'h00, 8'h81, 8'hF0};
        run_op(1'b0, 16'h5555, 1'b1, 10, 2, 1'b0, 8'hF0, 5, "R1", 1'b1);

        check(!busy && !bus_rd_req, "R2", "idle and quiet at end", {busy, bus_rd_req}, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule